// File: doc/BRIEF.md
# Two-Way Lockable Line Cache

This block is a small data cache that sits between a 32-bit core load/store port and a word-wide memory port. It stores 1 KB in two ways of 32 sets, with 16-byte lines. Lookup uses the physical address exactly as the core presents it. A read miss fetches the whole line as a four-word burst. The core's word is returned only after the fourth beat has arrived.

Each set has one least-recently-used bit, which picks the way to replace. Each line also has a lock bit that keeps it resident. A lock command stores the addressed line and pins it. If the least-recently-used way is pinned, the other way is replaced instead. If both ways are pinned, the miss is served straight from memory and no line is allocated. An unlock command releases every pin at once. Writes go through to memory and do not allocate a line.

The core presents one request at a time, holds `req_valid` for a single cycle, and waits for the one-cycle `core_ready` strobe before it sends the next request.

Top module: `lockcache`

## Requirements
- R1: While reset is asserted, and right after it, `core_ready`, `mem_rd` and `mem_wr` are low. Reset invalidates every line and clears every lock and LRU bit, so the first read of any address after reset misses.
- R2: The address is split into word = bits [3:2], set = bits [8:4] and tag = bits [31:9]. A lookup hits when a valid line in either way of the set holds the tag, and at most one way hits. Different sets are independent.
- R3: A read (`req_op` = 0) that hits pulses `core_ready` for one cycle, in the cycle after the request, with the cached word on `core_rdata`. No memory read is issued.
- R4: A read that misses pulses `mem_rd` for one cycle, in the cycle after the request, with `mem_addr` set to the line address (bits [3:0] zero). The cache takes four `mem_rvalid` beats in word order 0 to 3. It pulses `core_ready` in the cycle after the fourth beat, with the requested word.
- R5: Each set holds one LRU bit. After every hit and every fill, the bit points at the way not just used. On a miss, the way it points at is replaced, unless that way is locked.
- R6: A locked line is never replaced. If the LRU way is locked and the other way is not, the other way is filled.
- R7: If both ways of the set are locked, a miss still fetches the burst and returns the word, but allocates nothing. A repeated access to the same address misses again.
- R8: A write (`req_op` = 1) pulses `mem_wr` with the request's address and data, and `core_ready`, both in the cycle after the request. A write hit also updates the cached word. A write miss allocates no line.
- R9: A lock command (`req_op` = 2) sets the lock bit of the way that holds the line if it hits. If it misses, the line is filled as for a read and then locked. `core_ready` follows the same timing as R3 or R4.
- R10: An unlock command (`req_op` = 3) clears every lock bit and pulses `core_ready` in the cycle after the request. Lines that were locked become replaceable again.
- R11: A request presented while a refill is in progress is ignored. It produces no memory access and no extra `core_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe from the core, one cycle long |
| req_op | input | 2 | 0 read, 1 write, 2 lock line, 3 unlock all |
| req_addr | input | 32 | Physical byte address of the request |
| req_wdata | input | 32 | Write data |
| core_ready | output | 1 | One-cycle completion strobe |
| core_rdata | output | 32 | Read data, valid while `core_ready` is high |
| mem_rd | output | 1 | One-cycle burst read request |
| mem_wr | output | 1 | One-cycle single-word write |
| mem_addr | output | 32 | Line address for `mem_rd`, byte address for `mem_wr` |
| mem_wdata | output | 32 | Data for `mem_wr` |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
Hits, writes and unlock commands complete in the cycle after the request, and a write's `mem_wr` shares that cycle. A miss raises `mem_rd` one cycle after the request. The bench memory starts its four beats two cycles after that, so `core_ready` is due exactly seven cycles after the request. For every request the bench counts cycles from the request to `core_ready` and requires the exact figure. It then waits one more cycle before it compares the burst and write counters, so that any memory activity triggered by the request has been counted.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } lc_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } lc_state_e;

  // Victim choice: returns {usable, way}. Follow LRU, skip a locked way,
  // give up when both ways are locked.
  function automatic logic [1:0] pick_victim(input logic lru, input logic [1:0] locked);
    if (!locked[lru])  return {1'b1, lru};
    if (!locked[!lru]) return {1'b1, !lru};
    return 2'b00;
  endfunction

  // Line-aligned address: clears the offset bits.
  function automatic logic [31:0] line_base(input logic [31:0] a, input int off_bits);
    return (a >> off_bits) << off_bits;
  endfunction

endpackage

// File: rtl/lc_tagdir.sv
module lc_tagdir #(
  parameter int SETS  = 32,
  parameter int TAG_W = 23,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit,
  output logic [1:0]       lk_lock,
  output logic             lk_lru,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic             fill_lock,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic [SET_W-1:0] touch_set,
  input  logic             lock_en,
  input  logic             lock_way,
  input  logic [SET_W-1:0] lock_set,
  input  logic             clr_locks
);

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= !touch_way;
  end

  assign lk_lru = lru_q[lk_set];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        lock_q  <= '0;
      end else begin
        if (clr_locks) lock_q <= '0;
        if (lock_en && lock_way == 1'(w)) lock_q[lock_set] <= 1'b1;
        if (fill_en && fill_way == 1'(w)) begin
          valid_q[fill_set] <= 1'b1;
          lock_q[fill_set]  <= fill_lock;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[fill_set] <= fill_tag;
    end

    assign hit[w]     = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign lk_lock[w] = lock_q[lk_set];

    AST_FILL_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_way == 1'(w)) |-> !lock_q[fill_set]); // R6
  end

  AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R2

  AST_LOCKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_locks |=> (lk_lock == 2'b00)); // R10

endmodule

// File: rtl/lc_dataram.sv
module lc_dataram #(
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  parameter int DW         = 32,
  localparam int IDX_W     = $clog2(SETS * LINE_WORDS)
) (
  input  logic                clk,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [1:0][DW-1:0]  rd_data,
  input  logic                wr_en,
  input  logic                wr_way,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DW-1:0]       wr_data
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DW-1:0] mem_q [SETS * LINE_WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data[w] = mem_q[rd_idx];
  end

endmodule

// File: rtl/lockcache.sv
module lockcache #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          core_ready,
  output logic [DW-1:0] core_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  import lc_pkg::*;

  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WORD_W + 2;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = AW - OFF_W - SET_W;
  localparam int LINE_W = AW - OFF_W;
  localparam int IDX_W  = SET_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  // request fields
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WORD_W-1:0] req_word;
  assign req_set  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[AW-1 -: TAG_W];
  assign req_word = req_addr[2 +: WORD_W];

  // state
  lc_state_e         st_q;
  logic [LINE_W-1:0] pend_line_q;
  logic [WORD_W-1:0] pend_word_q;
  logic              pend_lock_q;
  logic              alloc_q;
  logic              vway_q;
  logic [WORD_W-1:0] beat_q;

  logic [SET_W-1:0]  pend_set;
  logic [TAG_W-1:0]  pend_tag;
  assign pend_set = pend_line_q[SET_W-1:0];
  assign pend_tag = pend_line_q[LINE_W-1 -: TAG_W];

  // lookup
  logic [1:0]           hit;
  logic [1:0]           set_locks;
  logic                 set_lru;
  logic                 hit_any;
  logic                 hit_way;
  logic [1:0][DW-1:0]   way_data;
  logic [1:0]           victim;
  assign hit_any = |hit;
  assign hit_way = hit[1];
  assign victim  = pick_victim(set_lru, set_locks);

  // named events
  logic in_idle, acc_req, is_read_like, ev_access_hit, ev_write, ev_write_hit, ev_miss;
  logic ev_unlock, ev_beat, ev_last, fill_en, touch_en, lock_en, dwe, dway;
  logic [SET_W-1:0] touch_set;
  logic [IDX_W-1:0] didx;
  logic [DW-1:0]    ddata;

  assign in_idle       = (st_q == ST_IDLE);
  assign acc_req       = in_idle && req_valid;
  assign is_read_like  = (req_op == OP_READ) || (req_op == OP_LOCK);
  assign ev_access_hit = acc_req && is_read_like && hit_any;
  assign ev_miss       = acc_req && is_read_like && !hit_any;
  assign ev_write      = acc_req && (req_op == OP_WRITE);
  assign ev_write_hit  = ev_write && hit_any;
  assign ev_unlock     = acc_req && (req_op == OP_UNLOCK);
  assign ev_beat       = (st_q == ST_FILL) && mem_rvalid;
  assign ev_last       = ev_beat && (beat_q == LAST_BEAT);
  assign fill_en       = ev_last && alloc_q;
  assign touch_en      = ev_access_hit || ev_write_hit || fill_en;
  assign touch_set     = fill_en ? pend_set : req_set;
  assign lock_en       = ev_access_hit && (req_op == OP_LOCK);
  assign dwe           = ev_write_hit || (ev_beat && alloc_q);
  assign dway          = ev_beat ? vway_q : hit_way;
  assign didx          = ev_beat ? {pend_set, beat_q} : {req_set, req_word};
  assign ddata         = ev_beat ? mem_rdata : req_wdata;

  lc_tagdir #(.SETS(SETS), .TAG_W(TAG_W)) u_tagdir (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (req_set),
    .lk_tag    (req_tag),
    .hit       (hit),
    .lk_lock   (set_locks),
    .lk_lru    (set_lru),
    .fill_en   (fill_en),
    .fill_way  (vway_q),
    .fill_lock (pend_lock_q),
    .fill_set  (pend_set),
    .fill_tag  (pend_tag),
    .touch_en  (touch_en),
    .touch_way (fill_en ? vway_q : hit_way),
    .touch_set (touch_set),
    .lock_en   (lock_en),
    .lock_way  (hit_way),
    .lock_set  (req_set),
    .clr_locks (ev_unlock)
  );

  lc_dataram #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DW(DW)) u_data (
    .clk     (clk),
    .rd_idx  ({req_set, req_word}),
    .rd_data (way_data),
    .wr_en   (dwe),
    .wr_way  (dway),
    .wr_idx  (didx),
    .wr_data (ddata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      core_ready  <= 1'b0;
      core_rdata  <= '0;
      mem_rd      <= 1'b0;
      mem_wr      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      pend_line_q <= '0;
      pend_word_q <= '0;
      pend_lock_q <= 1'b0;
      alloc_q     <= 1'b0;
      vway_q      <= 1'b0;
      beat_q      <= '0;
    end else begin
      core_ready <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      if (ev_unlock) core_ready <= 1'b1;
      if (ev_write) begin
        mem_wr     <= 1'b1;
        mem_addr   <= req_addr;
        mem_wdata  <= req_wdata;
        core_ready <= 1'b1;
      end
      if (ev_access_hit) begin
        core_ready <= 1'b1;
        core_rdata <= way_data[hit_way];
      end
      if (ev_miss) begin
        st_q        <= ST_FILL;
        mem_rd      <= 1'b1;
        mem_addr    <= AW'(line_base(32'(req_addr), OFF_W));
        pend_line_q <= req_addr[AW-1:OFF_W];
        pend_word_q <= req_word;
        pend_lock_q <= (req_op == OP_LOCK);
        alloc_q     <= victim[1];
        vway_q      <= victim[0];
        beat_q      <= '0;
      end
      if (ev_beat) begin
        beat_q <= beat_q + 1'b1;
        if (beat_q == pend_word_q) core_rdata <= mem_rdata;
      end
      if (ev_last) begin
        st_q       <= ST_IDLE;
        core_ready <= 1'b1;
      end
    end
  end

  AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R4

  AST_FILL_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> core_ready); // R4

  AST_READY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |=> !core_ready); // R3

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (mem_wr && core_ready)); // R8

  AST_NO_RD_WR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |=> !mem_wr); // R11

endmodule

// File: tb/lockcache_bench.sv
module lockcache_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        core_ready;
  logic [31:0] core_rdata;
  logic        mem_rd;
  logic        mem_wr;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk; // 250 MHz

  lockcache u_lockcache (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .core_ready (core_ready),
    .core_rdata (core_rdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  // memory model: 4 KB, burst starts two cycles after mem_rd
  logic [31:0] bmem [1024];
  int          rd_cnt, wr_cnt, rdy_cnt;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic        burst_on;
  logic [9:0]  burst_base;
  int          burst_n;
  int          checks, errors;

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    rd_cnt = 0; wr_cnt = 0; rdy_cnt = 0; burst_on = 1'b0; burst_n = 0;
    burst_base = '0; last_rd_addr = '0; last_wr_addr = '0; last_wr_data = '0;
    checks = 0; errors = 0;
  end

  always @(posedge clk) begin
    if (core_ready) rdy_cnt = rdy_cnt + 1;
    if (mem_wr) begin
      wr_cnt = wr_cnt + 1;
      last_wr_addr = mem_addr;
      last_wr_data = mem_wdata;
      bmem[mem_addr[11:2]] = mem_wdata;
    end
    if (mem_rd) begin
      rd_cnt = rd_cnt + 1;
      last_rd_addr = mem_addr;
      burst_on = 1'b1;
      burst_n = 0;
      burst_base = mem_addr[11:2];
      mem_rvalid <= 1'b0;
    end else if (burst_on) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= bmem[burst_base + 10'(burst_n)];
      burst_n = burst_n + 1;
      if (burst_n == 4) burst_on = 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic string req_name(input logic [1:0] op, input logic fill);
    case (op)
      2'd1:    return "R8";
      2'd2:    return "R9";
      2'd3:    return "R10";
      default: return fill ? "R4" : "R3";
    endcase
  endfunction

  // one request; latency counted in cycles from the request cycle
  task automatic run(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                     input logic exp_fill, input string rq);
    int rd0, wr0, lat;
    logic [31:0] expd, got;
    rd0 = rd_cnt; wr0 = wr_cnt;
    expd = bmem[addr[11:2]];
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!core_ready && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    got = core_rdata;
    chk(rq, "latency", 32'(lat), (exp_fill ? 32'd7 : 32'd1));
    @(negedge clk);
    chk(rq, "burst count", 32'(rd_cnt - rd0), {31'd0, exp_fill});
    if (exp_fill) chk(rq, "burst address", last_rd_addr, {addr[31:4], 4'h0});
    if (op == 2'd0 || op == 2'd2) chk(rq, "read data", got, expd);
    if (op == 2'd1) begin
      chk(rq, "write count", 32'(wr_cnt - wr0), 32'd1);
      chk(rq, "write address", last_wr_addr, addr);
      chk(rq, "write data", last_wr_data, wd);
    end else begin
      chk(rq, "no write", 32'(wr_cnt - wr0), 32'd0);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        fill;
  } vec_t;

  localparam int NV = 28;
  // set 0 lines: A=0x000 B=0x200 C=0x400 D=0x600 (R2 tag bits [31:9])
  localparam vec_t VEC [NV] = '{
    '{2'd0, 12'h004, 32'h0, 1'b1},           // A miss, way0
    '{2'd0, 12'h008, 32'h0, 1'b0},           // A hit
    '{2'd0, 12'h014, 32'h0, 1'b1},           // set 1 miss (R2)
    '{2'd0, 12'h018, 32'h0, 1'b0},           // set 1 hit (R2)
    '{2'd0, 12'h200, 32'h0, 1'b1},           // B miss, way1
    '{2'd0, 12'h000, 32'h0, 1'b0},           // A hit, LRU -> way1
    '{2'd0, 12'h400, 32'h0, 1'b1},           // C replaces B (R5)
    '{2'd0, 12'h000, 32'h0, 1'b0},           // A kept (R5)
    '{2'd0, 12'h200, 32'h0, 1'b1},           // B replaces C
    '{2'd0, 12'h400, 32'h0, 1'b1},           // C replaces A (R5)
    '{2'd0, 12'h000, 32'h0, 1'b1},           // A replaces B
    '{2'd1, 12'h004, 32'h1111_2222, 1'b0},   // write hit
    '{2'd0, 12'h004, 32'h0, 1'b0},           // hit returns written word
    '{2'd1, 12'h608, 32'h3333_4444, 1'b0},   // write miss, no allocate
    '{2'd0, 12'h608, 32'h0, 1'b1},           // D misses, replaces C
    '{2'd0, 12'h000, 32'h0, 1'b0},           // A hit
    '{2'd2, 12'h200, 32'h0, 1'b1},           // lock B on miss (R9)
    '{2'd0, 12'h400, 32'h0, 1'b1},           // C replaces A
    '{2'd0, 12'h600, 32'h0, 1'b1},           // LRU way locked, D goes to other (R6)
    '{2'd0, 12'h200, 32'h0, 1'b0},           // locked B still present (R6)
    '{2'd2, 12'h600, 32'h0, 1'b0},           // lock D on hit (R9)
    '{2'd0, 12'h000, 32'h0, 1'b1},           // both locked, bypass (R7)
    '{2'd0, 12'h000, 32'h0, 1'b1},           // not allocated (R7)
    '{2'd0, 12'h200, 32'h0, 1'b0},           // B hit
    '{2'd0, 12'h600, 32'h0, 1'b0},           // D hit
    '{2'd3, 12'h000, 32'h0, 1'b0},           // unlock all (R10)
    '{2'd0, 12'h000, 32'h0, 1'b1},           // A replaces B
    '{2'd0, 12'h200, 32'h0, 1'b1}            // B was released (R10)
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rd0, wr0, r0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {29'd0, core_ready, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {29'd0, core_ready, mem_rd, mem_wr}, 32'd0);

    for (int i = 0; i < NV; i++)
      run(VEC[i].op, {20'd0, VEC[i].addr}, VEC[i].wd, VEC[i].fill, req_name(VEC[i].op, VEC[i].fill));

    // R11: a write presented mid-refill is dropped
    rd0 = rd_cnt; wr0 = wr_cnt; r0 = rdy_cnt;
    req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h800;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 32'h804; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11", "writes during refill", 32'(wr_cnt - wr0), 32'd0);
    chk("R11", "ready strobes", 32'(rdy_cnt - r0), 32'd1);
    chk("R11", "bursts", 32'(rd_cnt - rd0), 32'd1);

    // R1: reset invalidates a cached line
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd0, 32'h000, 32'h0, 1'b1, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule